// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a serial peripheral slave that lets a host read and write a small set of internal configuration registers. The link uses SPI mode 3. The serial clock idles high, the host samples on rising edges, and the slave changes its output on falling edges. Every transaction opens with a one-byte command. The command names the register and the direction. A data phase follows, and its length is set by the register that was addressed. When that phase ends, the slave waits for the next command byte.

The serial pins are oversampled by the block's system clock. The pins are assumed to be already synchronous to that clock. Framing has two modes:

- Chip select in use: raising it cancels the current transaction. The register contents are kept.
- Chip select tied low: framing relies only on bit counting. A run of consecutive ones on the data input puts the whole block back to its defaults.

The register contents are presented continuously on parallel output ports. A 32-bit input word can be read through a read-only address.

Top module: `spi_reg_slave`

## Requirements
- R1: After `rstN` is released, `ctrlOut` = 0x0A, `modeOut` = 0x8000, `gainOut` = 0x400000 and `misoOut` = 1.
- R2: A command byte is shifted MSB first.
  - Bit 7 must be 0 for the command to be valid.
  - Bit 6 = 1 means read and bit 6 = 0 means write.
  - Bits 5:0 are the address.
  - A byte with bit 7 = 1 is discarded, and the next byte is taken as a new command.
- R3: The data phase length depends on the address: 1 → 8 bits, 2 → 16 bits, 3 → 24 bits, 4 → 32 bits, and any other address → 8 bits.
- R4: Write data is shifted MSB first. The target register at address 1 (ctrl), 2 (mode) or 3 (gain) changes only once the last data bit has been sampled. Before that, its old value is kept.
- R5: Read data appears on `misoOut` MSB first. The first bit is launched on the falling edge that follows the last command bit. Address 4 returns `sampleIn` as it was when the command completed.
- R6: An address with no register behind it reads as zeros and ignores writes. Framing resumes correctly after its 8-bit phase.
- R7: Raising `csN` cancels any transaction in progress. The registers are left unchanged, `misoOut` returns high, and the next command is decoded normally.
- R8: With `csN` held low throughout, back-to-back transactions are framed by bit counting alone.
- R9: 64 consecutive ones sampled on `mosi` return every register to its reset value and realign the slave to a command boundary. 63 ones followed by a zero have no effect on the registers.
- R10: `misoOut` is 1 whenever no read data phase is active, including during command and write phases.
- R11: A write to address 4 takes a 32-bit phase and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select; may be tied low |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host |
| misoOut | output | 1 | Serial data to host, high when idle |
| sampleIn | input | 32 | Word returned by reads of address 4 |
| ctrlOut | output | 8 | Control register contents |
| modeOut | output | 16 | Mode register contents |
| gainOut | output | 24 | Gain register contents |

## Verification
The assertions assume the following about the block's inputs:
- `sclk`, `csN` and `mosi` change only between system clock edges.
- Each `sclk` level is held for several system clocks, so every serial edge is seen exactly once.

The bench keeps within these assumptions in the following way:
- It drives all three pins on falling clock edges.
- It holds each serial half-period for four system clocks.
- It never produces a sub-cycle pulse.

The bench also avoids 64 consecutive ones except in the resync scenario, so the other register checks are not disturbed by an unintended reset.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam logic [5:0] ADDR_CTRL   = 6'd1;
  localparam logic [5:0] ADDR_MODE   = 6'd2;
  localparam logic [5:0] ADDR_GAIN   = 6'd3;
  localparam logic [5:0] ADDR_SAMPLE = 6'd4;

  typedef struct packed {
    logic       shiftIn;   // rising serial edge: capture mosi
    logic       loadTx;    // read command accepted: load transmit word
    logic       shiftOut;  // falling serial edge inside read phase
    logic       holdMiso;  // no read phase active
    logic       commit;    // last write bit sampled
    logic       softRst;   // resync run complete
    logic [5:0] addr;      // register being addressed
  } ctrlStrobes_t;

  function automatic logic [5:0] phaseBits(input logic [5:0] addr);
    case (addr)
      ADDR_MODE:   return 6'd16;
      ADDR_GAIN:   return 6'd24;
      ADDR_SAMPLE: return 6'd32;
      default:     return 6'd8;
    endcase
  endfunction
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_regs_pkg::*;
#(
  parameter int RESYNC_ONES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         mosi,
  input  logic [6:0]   rxLow,
  output ctrlStrobes_t st
);
  localparam int ONES_W = $clog2(RESYNC_ONES + 1);

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD} phase_t;

  phase_t              phase;
  logic                sclkQ;
  logic [5:0]          bitCnt;
  logic [5:0]          addrQ;
  logic [5:0]          lenQ;
  logic [ONES_W-1:0]   onesCnt;
  logic                rise, fall, lastBit, resyncHit, cmdDone;
  logic [7:0]          cmdByte;

  assign rise      = !csN && sclk && !sclkQ;
  assign fall      = !csN && !sclk && sclkQ;
  assign cmdByte   = {rxLow, mosi};
  assign lastBit   = (bitCnt == lenQ - 6'd1);
  assign cmdDone   = rise && (phase == S_CMD) && (bitCnt == 6'd7);
  assign resyncHit = rise && mosi && (onesCnt == ONES_W'(RESYNC_ONES - 1));

  always_comb begin
    st          = '0;
    st.shiftIn  = rise;
    st.loadTx   = cmdDone && !cmdByte[7] && cmdByte[6];
    st.shiftOut = fall && (phase == S_RD);
    st.holdMiso = (phase != S_RD);
    st.commit   = rise && (phase == S_WR) && lastBit;
    st.softRst  = resyncHit;
    st.addr     = (phase == S_CMD) ? cmdByte[5:0] : addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b1;
      phase   <= S_CMD;
      bitCnt  <= '0;
      addrQ   <= '0;
      lenQ    <= 6'd8;
      onesCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN || resyncHit) begin
        phase   <= S_CMD;
        bitCnt  <= '0;
        onesCnt <= '0;
      end else if (rise) begin
        onesCnt <= mosi ? onesCnt + 1'b1 : '0;
        if (phase == S_CMD) begin
          if (bitCnt == 6'd7) begin
            bitCnt <= '0;
            if (!cmdByte[7]) begin
              addrQ <= cmdByte[5:0];
              lenQ  <= phaseBits(cmdByte[5:0]);
              phase <= cmdByte[6] ? S_RD : S_WR;
            end
          end else begin
            bitCnt <= bitCnt + 6'd1;
          end
        end else if (lastBit) begin
          phase  <= S_CMD;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_regs_pkg::*;
#(
  parameter logic [7:0]  CTRL_RST = 8'h0A,
  parameter logic [15:0] MODE_RST = 16'h8000,
  parameter logic [23:0] GAIN_RST = 24'h400000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mosi,
  input  ctrlStrobes_t st,
  input  logic [31:0]  sampleIn,
  output logic [6:0]   rxLow,
  output logic [7:0]   ctrlReg,
  output logic [15:0]  modeReg,
  output logic [23:0]  gainReg,
  output logic         misoOut
);
  logic [22:0] rxShift;
  logic [23:0] wordIn;
  logic [31:0] txShift;
  logic [31:0] readVal;

  assign wordIn = {rxShift, mosi};
  assign rxLow  = rxShift[6:0];

  always_comb begin
    case (st.addr)
      ADDR_CTRL:   readVal = {ctrlReg, 24'h0};
      ADDR_MODE:   readVal = {modeReg, 16'h0};
      ADDR_GAIN:   readVal = {gainReg, 8'h0};
      ADDR_SAMPLE: readVal = sampleIn;
      default:     readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ctrlReg <= CTRL_RST;
      modeReg <= MODE_RST;
      gainReg <= GAIN_RST;
      misoOut <= 1'b1;
    end else begin
      if (st.shiftIn) rxShift <= wordIn[22:0];

      if (st.softRst) begin
        ctrlReg <= CTRL_RST;
        modeReg <= MODE_RST;
        gainReg <= GAIN_RST;
      end else if (st.commit) begin
        case (st.addr)
          ADDR_CTRL: ctrlReg <= wordIn[7:0];
          ADDR_MODE: modeReg <= wordIn[15:0];
          ADDR_GAIN: gainReg <= wordIn;
          default:   ;
        endcase
      end

      if (st.loadTx)        txShift <= readVal;
      else if (st.shiftOut) txShift <= {txShift[30:0], 1'b0};

      if (st.softRst || st.holdMiso) misoOut <= 1'b1;
      else if (st.shiftOut)          misoOut <= txShift[31];
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int          RESYNC_ONES = 64,
  parameter logic [7:0]  CTRL_RST    = 8'h0A,
  parameter logic [15:0] MODE_RST    = 16'h8000,
  parameter logic [23:0] GAIN_RST    = 24'h400000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        mosi,
  output logic        misoOut,
  input  logic [31:0] sampleIn,
  output logic [7:0]  ctrlOut,
  output logic [15:0] modeOut,
  output logic [23:0] gainOut
);
  ctrlStrobes_t st;
  logic [6:0]   rxLow;

  spi_reg_ctrl #(.RESYNC_ONES(RESYNC_ONES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .rxLow(rxLow), .st(st)
  );

  spi_reg_datapath #(.CTRL_RST(CTRL_RST), .MODE_RST(MODE_RST), .GAIN_RST(GAIN_RST)) dp_i (
    .clk(clk), .rstN(rstN), .mosi(mosi), .st(st), .sampleIn(sampleIn),
    .rxLow(rxLow), .ctrlReg(ctrlOut), .modeReg(modeOut), .gainReg(gainOut),
    .misoOut(misoOut)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_regs_pkg::*;
#(
  parameter logic [7:0]  CTRL_RST = 8'h0A,
  parameter logic [15:0] MODE_RST = 16'h8000,
  parameter logic [23:0] GAIN_RST = 24'h400000
) (
  input logic         clk,
  input logic         rstN,
  input logic         csN,
  input logic         sclk,
  input logic         misoOut,
  input logic [7:0]   ctrlOut,
  input logic [15:0]  modeOut,
  input logic [23:0]  gainOut,
  input ctrlStrobes_t st
);
  // R4
  regs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclk) == $past(sclk, 2)) |-> $stable({ctrlOut, modeOut, gainOut}));

  // R9
  resync_defaults_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.softRst |=> (ctrlOut == CTRL_RST && modeOut == MODE_RST && gainOut == GAIN_RST));

  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.holdMiso) |-> misoOut);

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && $past(csN, 2)) |-> misoOut);

  // R5
  miso_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(st.shiftOut) && !$past(st.holdMiso) && !$past(st.softRst)) |-> $stable(misoOut));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .CTRL_RST(CTRL_RST), .MODE_RST(MODE_RST), .GAIN_RST(GAIN_RST)
) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .misoOut(misoOut),
  .ctrlOut(ctrlOut), .modeOut(modeOut), .gainOut(gainOut), .st(st)
);

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        mosi = 1'b0;
  logic        misoOut;
  logic [31:0] sampleIn = 32'h0;
  logic [7:0]  ctrlOut;
  logic [15:0] modeOut;
  logic [23:0] gainOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  spi_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .misoOut(misoOut), .sampleIn(sampleIn),
    .ctrlOut(ctrlOut), .modeOut(modeOut), .gainOut(gainOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitIo(input logic b, output logic rd);
    @(negedge clk);
    sclk = 1'b0;
    mosi = b;
    repeat (4) @(negedge clk);
    rd   = misoOut;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic shiftWord(input logic [31:0] val, input int n, output logic [31:0] rd);
    logic b;
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitIo(val[i], b);
      rd = {rd[30:0], b};
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int n, input logic [31:0] wdata,
                      output logic [31:0] cmdRd, output logic [31:0] rdata);
    shiftWord({24'h0, cmd}, 8, cmdRd);
    shiftWord(wdata, n, rdata);
  endtask

  task automatic frameEnd();
    @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkRegs(input string req, input logic [7:0] c, input logic [15:0] m,
                           input logic [23:0] g);
    check(req, {24'h0, ctrlOut}, {24'h0, c});
    check(req, {16'h0, modeOut}, {16'h0, m});
    check(req, {8'h0, gainOut}, {8'h0, g});
  endtask

  task automatic testReset();
    checkRegs("R1 reset values", 8'h0A, 16'h8000, 24'h400000);
    check("R1 miso idle after reset", {31'h0, misoOut}, 32'h1);
  endtask

  task automatic testWriteRead();
    logic [31:0] c, r;
    csN = 1'b0;
    xfer(8'h01, 8, 32'hA5, c, r);
    check("R10 miso high in command phase", c, 32'hFF);
    check("R10 miso high in write phase", r, 32'hFF);
    xfer(8'h02, 16, 32'h1234, c, r);
    check("R10 miso high in 16-bit write", r, 32'hFFFF);
    xfer(8'h03, 24, 32'hABCDEF, c, r);
    checkRegs("R3 R4 writes of 8/16/24 bits", 8'hA5, 16'h1234, 24'hABCDEF);
    xfer(8'h41, 8, 32'h0, c, r);
    check("R5 read ctrl", r, 32'hA5);
    xfer(8'h42, 16, 32'h0, c, r);
    check("R5 read mode", r, 32'h1234);
    xfer(8'h43, 24, 32'h0, c, r);
    check("R5 read gain", r, 32'hABCDEF);
    sampleIn = 32'hDEADBEEF;
    xfer(8'h44, 32, 32'h0, c, r);
    check("R5 R3 read 32-bit sample", r, 32'hDEADBEEF);
    frameEnd();
  endtask

  task automatic testPartialCommit();
    logic [31:0] c, r;
    logic b;
    csN = 1'b0;
    shiftWord(32'h02, 8, c);
    shiftWord(32'h2B3C >> 1, 15, r);
    check("R4 no update before last bit", {16'h0, modeOut}, 32'h1234);
    bitIo(1'b0, b);
    check("R4 update after last bit", {16'h0, modeOut}, 32'h2B3C);
    frameEnd();
  endtask

  task automatic testUnimplemented();
    logic [31:0] c, r;
    csN = 1'b0;
    xfer(8'h15, 8, 32'h77, c, r);
    checkRegs("R6 write to empty address ignored", 8'hA5, 16'h2B3C, 24'hABCDEF);
    xfer(8'h55, 8, 32'h0, c, r);
    check("R6 empty address reads zero", r, 32'h0);
    xfer(8'h41, 8, 32'h0, c, r);
    check("R6 framing after empty address", r, 32'hA5);
    frameEnd();
  endtask

  task automatic testInvalidCmd();
    logic [31:0] c, r;
    csN = 1'b0;
    shiftWord(32'h81, 8, c);
    xfer(8'h01, 8, 32'h3C, c, r);
    check("R2 byte with bit7 set discarded", {24'h0, ctrlOut}, 32'h3C);
    frameEnd();
  endtask

  task automatic testReadOnly();
    logic [31:0] c, r;
    csN = 1'b0;
    xfer(8'h04, 32, 32'h12345678, c, r);
    checkRegs("R11 write to read-only address", 8'h3C, 16'h2B3C, 24'hABCDEF);
    xfer(8'h42, 16, 32'h0, c, r);
    check("R11 framing after 32-bit write", r, 32'h2B3C);
    frameEnd();
  endtask

  task automatic testAbort();
    logic [31:0] c, r;
    csN = 1'b0;
    shiftWord(32'h03, 8, c);
    shiftWord(32'h0F0, 12, r);
    frameEnd();
    check("R7 aborted write leaves gain", {8'h0, gainOut}, 32'hABCDEF);
    csN = 1'b0;
    shiftWord(32'h43, 8, c);
    shiftWord(32'h0, 10, r);
    check("R7 partial read data", r, 32'h2AF);
    frameEnd();
    check("R7 miso high after abort", {31'h0, misoOut}, 32'h1);
    csN = 1'b0;
    xfer(8'h01, 8, 32'h5A, c, r);
    check("R7 next command after abort", {24'h0, ctrlOut}, 32'h5A);
    frameEnd();
  endtask

  task automatic testTiedLow();
    logic [31:0] c, r;
    csN = 1'b0;
    xfer(8'h02, 16, 32'hC0DE, c, r);
    xfer(8'h01, 8, 32'h66, c, r);
    xfer(8'h42, 16, 32'h0, c, r);
    check("R8 back-to-back read mode", r, 32'hC0DE);
    xfer(8'h41, 8, 32'h0, c, r);
    check("R8 back-to-back read ctrl", r, 32'h66);
    frameEnd();
  endtask

  task automatic testResync();
    logic [31:0] c, r;
    csN = 1'b0;
    shiftWord(32'hFFFFFFFF, 32, r);
    shiftWord(32'hFFFFFFFE, 32, r);
    checkRegs("R9 63 ones do not reset", 8'h66, 16'hC0DE, 24'hABCDEF);
    shiftWord(32'hFFFFFFFF, 32, r);
    shiftWord(32'hFFFFFFFF, 32, r);
    checkRegs("R9 64 ones reset registers", 8'h0A, 16'h8000, 24'h400000);
    xfer(8'h01, 8, 32'h11, c, r);
    check("R9 aligned after resync", {24'h0, ctrlOut}, 32'h11);
    frameEnd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testWriteRead();
    testPartialCommit();
    testUnimplemented();
    testInvalidCmd();
    testReadOnly();
    testAbort();
    testTiedLow();
    testResync();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule